// File: doc/BRIEF.md
# ADC conversion rate sequencer

This block paces the results of two sigma-delta converter channels, a primary and an auxiliary. It receives a one-cycle enable for each modulator clock and counts those enables to decide when a filtered result would be ready. It does not produce the result itself. It only raises a one-cycle data-ready strobe on the channel concerned. Both channels share one 8-bit decimation setting. One output period lasts 24 times that setting, counted in modulator enables.

Each channel runs its own state machine. The states are `CH_IDLE`, `CH_SETTLE` (the first result after a start, which spans two periods because the inputs are chopped), `CH_RUN` (continuous mode, one period per result) and `CH_CAL` (calibration, timed with the decimation forced to 255). The transitions are:
- *launch*: `CH_IDLE` to `CH_SETTLE` on start.
- *calibrate*: `CH_IDLE` to `CH_CAL` on a calibrate request.
- *settled*: `CH_SETTLE` to `CH_RUN` in continuous mode, or back to `CH_IDLE` in single mode.
- *repeat*: `CH_RUN` to `CH_RUN` after each period.
- *cal-finish*: `CH_CAL` to `CH_IDLE`.
- *abort*: any busy state to `CH_IDLE` on stop.

The decimation register can only be written while both channels are idle. A write below the legal floor of 13 is clamped to 13.

Top module: `adc_rate_seq`

## Requirements
- R1: After reset the decimation readback is 0x45, and every busy, data-ready, calibration-done and write-error output is low.
- R2: A write while both channels are idle with a value from 0x0D to 0xFF appears unchanged on the readback in the following cycle.
- R3: A write while both channels are idle with a value below 0x0D stores 0x0D. It also raises the write-error output for exactly the one cycle after the write.
- R4: A write while either channel is busy is ignored: the readback keeps its value and no write error is raised.
- R5: One period is 24 × decimation modulator enables. Cycles without an enable do not advance the count, and the enable in the cycle that starts a channel is not counted.
- R6: The first data-ready after a start comes 48 × decimation enables later. Every data-ready lasts exactly one cycle.
- R7: In continuous mode, each later data-ready follows the previous one by 24 × decimation enables. In single mode, busy drops in the same cycle that data-ready rises.
- R8: Calibration lasts 48 × 255 enables whatever the user value is, and then pulses calibration-done for one cycle with busy low. The readback shows the user value throughout, and the next conversion uses the user value.
- R9: Stop on a busy channel returns it to idle in the next cycle, with no data-ready and no calibration-done.
- R10: The two channels share the decimation value but are timed independently. Channels started in the same cycle produce their data-ready in the same cycle.
- R11: Start and calibrate on a busy channel are ignored. On an idle channel, calibrate takes precedence over a start in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_tick | input | 1 | One-cycle enable per modulator clock |
| cfg_we | input | 1 | Decimation register write strobe |
| cfg_wdata | input | 8 | Decimation write value |
| cfg_rdata | output | 8 | User decimation value readback |
| cfg_err | output | 1 | One-cycle pulse when a write was clamped |
| ch_start | input | 2 | Per-channel start request |
| ch_cont | input | 2 | Per-channel mode at start: 1 continuous, 0 single |
| ch_stop | input | 2 | Per-channel abort request |
| ch_cal | input | 2 | Per-channel calibration request |
| ch_busy | output | 2 | Channel not in `CH_IDLE` |
| ch_drdy | output | 2 | One-cycle data-ready strobe |
| ch_cal_done | output | 2 | One-cycle calibration-finished strobe |

## Verification
The hardest case to reach is the calibration override meeting the write lock. A write has to arrive while a calibration is running at the forced value, and the conversion that follows has to be shown to return to the user value. The stimulus starts a calibration, issues a write in the next cycle and times the full 12240-enable window. It then launches a single conversion and measures its length in enables. Enable gaps are produced by a configurable tick divider, so that enable counting can be told apart from cycle counting.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        CH_IDLE,
        CH_SETTLE,
        CH_RUN,
        CH_CAL
    } ch_state_e;
endpackage

// File: rtl/adc_sf_reg.sv
module adc_sf_reg #(
    parameter int unsigned SF_W   = 8,
    parameter int unsigned SF_MIN = 13,
    parameter int unsigned SF_RST = 69
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [SF_W-1:0] wr_data,
    input  logic            lock,
    output logic [SF_W-1:0] sf,
    output logic            wr_err
);
    logic accept;
    logic below;

    assign accept = wr_en && !lock;
    assign below  = wr_data < SF_W'(SF_MIN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sf     <= SF_W'(SF_RST);
            wr_err <= 1'b0;
        end else begin
            wr_err <= accept && below;
            if (accept) begin
                sf <= below ? SF_W'(SF_MIN) : wr_data;
            end
        end
    end

    // R4: locked writes leave the register untouched
    assert_write_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock) |=> $stable(sf));

    // R3: stored value never falls below the floor
    assert_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sf >= SF_W'(SF_MIN));

    // R3: an error pulse only follows an accepted write
    assert_err_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en && !lock));
endmodule

// File: rtl/adc_ch_seq.sv
module adc_ch_seq
    import adc_seq_pkg::*;
#(
    parameter int unsigned SF_W   = 8,
    parameter int unsigned SF_MAX = 255,
    parameter int unsigned UNIT   = 24,
    parameter int unsigned CHOP   = 2,
    parameter int unsigned CNT_W  = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            start,
    input  logic            cont,
    input  logic            stop,
    input  logic            cal,
    input  logic [SF_W-1:0] sf,
    output logic            busy,
    output logic            drdy,
    output logic            cal_done
);
    ch_state_e        state;
    ch_state_e        state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] target;
    logic [SF_W-1:0]  eff_sf;
    logic             cont_q;
    logic             last;

    always_comb begin
        eff_sf = (state == CH_CAL) ? SF_W'(SF_MAX) : sf;
        period = CNT_W'(UNIT) * CNT_W'(eff_sf);
        target = (state == CH_RUN) ? period : CNT_W'(CHOP) * period;
        last   = tick && (cnt == target - CNT_W'(1));
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE: begin
                if (cal)        state_nx = CH_CAL;
                else if (start) state_nx = CH_SETTLE;
            end
            CH_SETTLE: begin
                if (stop)       state_nx = CH_IDLE;
                else if (last)  state_nx = cont_q ? CH_RUN : CH_IDLE;
            end
            CH_RUN: begin
                if (stop)       state_nx = CH_IDLE;
            end
            CH_CAL: begin
                if (stop || last) state_nx = CH_IDLE;
            end
            default: state_nx = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state == CH_IDLE || stop || last) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drdy     <= 1'b0;
            cal_done <= 1'b0;
            cont_q   <= 1'b0;
        end else begin
            drdy     <= !stop && last && (state == CH_SETTLE || state == CH_RUN);
            cal_done <= !stop && last && (state == CH_CAL);
            if (state == CH_IDLE && start && !cal) cont_q <= cont;
        end
    end

    assign busy = (state != CH_IDLE);

    // R5: the running count stays inside the current window
    assert_cnt_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt < target));

    // R6: data-ready is a single-cycle strobe
    assert_drdy_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drdy |=> !drdy);

    // R9: stop on a busy channel aborts with no result
    assert_stop_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && busy) |=> (!busy && !drdy && !cal_done));

    // R8: calibration completion leaves the channel idle
    assert_cal_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> !busy);
endmodule

// File: rtl/adc_rate_seq.sv
module adc_rate_seq #(
    parameter int unsigned SF_W   = 8,
    parameter int unsigned SF_MIN = 13,
    parameter int unsigned SF_MAX = 255,
    parameter int unsigned SF_RST = 69,
    parameter int unsigned UNIT   = 24,
    parameter int unsigned CHOP   = 2,
    parameter int unsigned N_CH   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mod_tick,
    input  logic            cfg_we,
    input  logic [SF_W-1:0] cfg_wdata,
    output logic [SF_W-1:0] cfg_rdata,
    output logic            cfg_err,
    input  logic [N_CH-1:0] ch_start,
    input  logic [N_CH-1:0] ch_cont,
    input  logic [N_CH-1:0] ch_stop,
    input  logic [N_CH-1:0] ch_cal,
    output logic [N_CH-1:0] ch_busy,
    output logic [N_CH-1:0] ch_drdy,
    output logic [N_CH-1:0] ch_cal_done
);
    localparam int unsigned CNT_W = $clog2(CHOP * UNIT * SF_MAX + 1);

    logic [SF_W-1:0] sf_user;
    logic            any_busy;

    assign any_busy = |ch_busy;

    adc_sf_reg #(
        .SF_W  (SF_W),
        .SF_MIN(SF_MIN),
        .SF_RST(SF_RST)
    ) u_sf_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_data(cfg_wdata),
        .lock   (any_busy),
        .sf     (sf_user),
        .wr_err (cfg_err)
    );

    assign cfg_rdata = sf_user;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        adc_ch_seq #(
            .SF_W  (SF_W),
            .SF_MAX(SF_MAX),
            .UNIT  (UNIT),
            .CHOP  (CHOP),
            .CNT_W (CNT_W)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (mod_tick),
            .start   (ch_start[g]),
            .cont    (ch_cont[g]),
            .stop    (ch_stop[g]),
            .cal     (ch_cal[g]),
            .sf      (sf_user),
            .busy    (ch_busy[g]),
            .drdy    (ch_drdy[g]),
            .cal_done(ch_cal_done[g])
        );
    end
endmodule

// File: tb/test_adc_rate_seq.sv
module test_adc_rate_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mod_tick = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       cfg_err;
    logic [1:0] ch_start = 2'b00;
    logic [1:0] ch_cont = 2'b00;
    logic [1:0] ch_stop = 2'b00;
    logic [1:0] ch_cal = 2'b00;
    logic [1:0] ch_busy;
    logic [1:0] ch_drdy;
    logic [1:0] ch_cal_done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int tick_div = 1;
    int phase = 0;
    bit cmp_on = 1'b0;

    // behavioural reference
    int       m_sf = 69;
    bit       m_err = 1'b0;
    bit [1:0] m_busy = 2'b00;
    bit [1:0] m_drdy = 2'b00;
    bit [1:0] m_cd = 2'b00;
    bit [1:0] m_iscal = 2'b00;
    bit [1:0] m_cont = 2'b00;
    int       m_rem [2];

    always #10 clk = ~clk;

    adc_rate_seq i_adc_rate_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mod_tick   (mod_tick),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cfg_err    (cfg_err),
        .ch_start   (ch_start),
        .ch_cont    (ch_cont),
        .ch_stop    (ch_stop),
        .ch_cal     (ch_cal),
        .ch_busy    (ch_busy),
        .ch_drdy    (ch_drdy),
        .ch_cal_done(ch_cal_done)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sf = 69; m_err = 0; m_busy = 0; m_drdy = 0; m_cd = 0;
        end else begin
            bit pre_busy;
            pre_busy = m_busy[0] | m_busy[1];
            m_err = 0;
            if (cfg_we && !pre_busy) begin
                if (cfg_wdata < 8'd13) begin m_sf = 13; m_err = 1; end
                else m_sf = int'(cfg_wdata);
            end
            for (int c = 0; c < 2; c++) begin
                m_drdy[c] = 0;
                m_cd[c] = 0;
                if (!m_busy[c]) begin
                    if (ch_cal[c]) begin
                        m_busy[c] = 1; m_iscal[c] = 1; m_rem[c] = 48 * 255;
                    end else if (ch_start[c]) begin
                        m_busy[c] = 1; m_iscal[c] = 0; m_cont[c] = ch_cont[c];
                        m_rem[c] = 48 * m_sf;
                    end
                end else if (ch_stop[c]) begin
                    m_busy[c] = 0;
                end else if (mod_tick) begin
                    m_rem[c] = m_rem[c] - 1;
                    if (m_rem[c] == 0) begin
                        if (m_iscal[c]) begin
                            m_cd[c] = 1; m_busy[c] = 0;
                        end else begin
                            m_drdy[c] = 1;
                            if (m_cont[c]) m_rem[c] = 24 * m_sf;
                            else m_busy[c] = 0;
                        end
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    task automatic compare_all();
        chk(cfg_rdata == 8'(m_sf), "R2 readback vs model", cfg_rdata, m_sf);
        chk(cfg_err == m_err, "R3 write error vs model", cfg_err, m_err);
        for (int c = 0; c < 2; c++) begin
            chk(ch_busy[c] == m_busy[c], "R9 busy vs model", ch_busy[c], m_busy[c]);
            chk(ch_drdy[c] == m_drdy[c], "R6 data-ready vs model", ch_drdy[c], m_drdy[c]);
            chk(ch_cal_done[c] == m_cd[c], "R8 cal-done vs model", ch_cal_done[c], m_cd[c]);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (cmp_on) compare_all();
        cfg_we = 0; ch_start = 0; ch_stop = 0; ch_cal = 0;
        mod_tick = (tick_div <= 1) ? 1'b1 : ((phase % tick_div) == 0);
        phase++;
    endtask

    // counts enables until the chosen strobe of channel c is seen
    task automatic measure(input int c, input bit want_cal, input bit from_now, output int ticks);
        ticks = (from_now && mod_tick) ? 1 : 0;
        step();
        for (int i = 0; i < 60000; i++) begin
            if (want_cal ? ch_cal_done[c] : ch_drdy[c]) break;
            if (mod_tick) ticks++;
            step();
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int t;
        repeat (3) step();
        rst_n = 1;
        step();
        cmp_on = 1;
        // R1 reset state
        chk(cfg_rdata == 8'h45, "R1 reset readback", cfg_rdata, 69);
        chk(ch_busy == 0 && ch_drdy == 0 && ch_cal_done == 0 && !cfg_err, "R1 reset outputs", 0, 0);

        // R2 / R3 writes while idle
        cfg_we = 1; cfg_wdata = 8'h0D; step();
        chk(cfg_rdata == 8'h0D, "R2 write floor value", cfg_rdata, 13);
        cfg_we = 1; cfg_wdata = 8'h05; step();
        chk(cfg_err == 1 && cfg_rdata == 8'h0D, "R3 clamp and error", cfg_rdata, 13);
        step();
        chk(cfg_err == 0, "R3 error lasts one cycle", cfg_err, 0);

        // R6 / R7 single conversion
        ch_start[0] = 1; ch_cont[0] = 0;
        measure(0, 0, 0, t);
        chk(t == 624, "R6 first result latency", t, 624);
        chk(ch_busy[0] == 0, "R7 single returns to idle", ch_busy[0], 0);
        step();
        chk(ch_drdy[0] == 0, "R6 strobe one cycle", ch_drdy[0], 0);

        // R10 both channels continuous together
        ch_start = 2'b11; ch_cont = 2'b11;
        measure(0, 0, 0, t);
        chk(t == 624, "R6 continuous first result", t, 624);
        chk(ch_drdy[1] == 1, "R10 channels aligned", ch_drdy[1], 1);
        // R4 locked write, R11 start while busy
        cfg_we = 1; cfg_wdata = 8'h20; ch_start[0] = 1; ch_cont[0] = 0;
        measure(0, 0, 1, t);
        chk(t == 312, "R7 continuous period", t, 312);
        chk(cfg_rdata == 8'h0D, "R4 write ignored while busy", cfg_rdata, 13);
        chk(ch_busy[0] == 1, "R11 start while busy ignored", ch_busy[0], 1);

        // R9 stop
        ch_stop[0] = 1; step();
        chk(ch_busy[0] == 0 && ch_drdy[0] == 0, "R9 stop aborts", ch_busy[0], 0);
        ch_stop[1] = 1; step();
        chk(ch_busy[1] == 0, "R9 stop second channel", ch_busy[1], 0);

        // R5 sparse enables
        cfg_we = 1; cfg_wdata = 8'h14; step();
        chk(cfg_rdata == 8'h14, "R2 write 0x14", cfg_rdata, 20);
        tick_div = 3;
        ch_start[1] = 1; ch_cont[1] = 0;
        measure(1, 0, 0, t);
        chk(t == 960, "R5 counts enables only", t, 960);
        tick_div = 1;

        // R8 calibration with write attempt during it
        ch_cal[0] = 1; step();
        cfg_we = 1; cfg_wdata = 8'h30;
        measure(0, 1, 1, t);
        chk(t == 12240, "R8 calibration length", t, 12240);
        chk(cfg_rdata == 8'h14, "R8 readback keeps user value", cfg_rdata, 20);
        chk(ch_busy[0] == 0, "R8 idle after calibration", ch_busy[0], 0);
        ch_start[0] = 1; ch_cont[0] = 0;
        measure(0, 0, 0, t);
        chk(t == 960, "R8 user value restored", t, 960);

        // R11 calibrate wins over start
        ch_cal[1] = 1; ch_start[1] = 1; ch_cont[1] = 0;
        measure(1, 1, 0, t);
        chk(t == 12240, "R11 calibrate precedence", t, 12240);

        // R2 upper bound and R3 boundary
        cfg_we = 1; cfg_wdata = 8'hFF; step();
        chk(cfg_rdata == 8'hFF, "R2 write 0xFF", cfg_rdata, 255);
        cfg_we = 1; cfg_wdata = 8'h0C; step();
        chk(cfg_rdata == 8'h0D && cfg_err, "R3 clamp 0x0C", cfg_rdata, 13);
        repeat (4) step();

        summary();
        $finish;
    end
endmodule